// File: doc/BRIEF.md
# Two-Stage Partitioned Ternary Prefix Lookup

This block resolves a destination key to a next-hop value by longest-prefix match. It uses two ternary stages so that only a fraction of the rule table is compared on each search. A small first-level ternary table holds one prefix per partition. The lowest-numbered valid entry that matches the key reads a partition descriptor: a start row and a row count. In the following cycle, the large second-level ternary table compares only the rows inside that window. Every other row is held off. The lowest-numbered valid matching row in the window selects the next hop from a result store.

Software lays out each partition as a subtree of the rule set's binary trie. It orders the prefixes longest first, both in the first-level table and inside every partition, so a first match is always the longest match. Computing the partitions is not part of this block. The block provides write ports to load the first-level entries with their descriptors, and the second-level entries with their next hops.

Lookups are pipelined over two registered stages, and a new key can be taken on every cycle. Each result carries a hit flag, the next hop and the number of second-level rows that were enabled. With that count, the energy saving of a search can be measured directly. If both stages are sized near the square root of the table, a search costs roughly twice that many row compares.

Top module: `pfx_lookup`

## Requirements
- R1: After synchronous reset, every entry of both tables is invalid and `res_valid` is 0. A lookup on the empty tables returns `res_hit`=0, `res_hop`=0 and `res_rows`=0.
- R2: Each entry is ternary. A key bit is compared only where the entry's care bit is 1. The lowest-numbered valid first-level entry that matches the key selects the start row and row count written with that entry.
- R3: Only the second-level rows numbered start through start+count-1 are enabled, with the window clipped at the last row of the table. `res_rows` reports the number of enabled rows.
- R4: The next hop comes from the lowest-numbered valid matching row inside the window. A matching row outside the window has no effect on the result.
- R5: When no first-level entry matches, the result is `res_hit`=0, `res_hop`=0 and `res_rows`=0.
- R6: When the first level matches but no row in the window does, the result is `res_hit`=0 and `res_hop`=0, and `res_rows` still reports the window size.
- R7: A result appears with `res_valid`=1 exactly two clock edges after its key was sampled with `key_valid`=1. Back-to-back keys give back-to-back results in the same order. Without `key_valid`, `res_valid` stays 0.
- R8: A write on either port changes its row at that clock edge, and lookups sampled after that edge see the change. Writing a row with its valid bit at 0 removes the row from matching.
- R9: A first-level entry whose row count is 0 enables no rows and yields a miss with `res_rows`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | Key present this cycle |
| key | input | KEY_W | Lookup key |
| ix_wr_en | input | 1 | First-level write strobe |
| ix_wr_row | input | IX_AW | First-level row to write |
| ix_wr_valid | input | 1 | Valid bit for the written entry |
| ix_wr_value | input | KEY_W | Entry value bits |
| ix_wr_care | input | KEY_W | Entry care bits (1 = compare) |
| ix_wr_start | input | DT_AW | Partition start row |
| ix_wr_count | input | CNT_W | Partition row count |
| dt_wr_en | input | 1 | Second-level write strobe |
| dt_wr_row | input | DT_AW | Second-level row to write |
| dt_wr_valid | input | 1 | Valid bit for the written row |
| dt_wr_value | input | KEY_W | Row value bits |
| dt_wr_care | input | KEY_W | Row care bits (1 = compare) |
| dt_wr_hop | input | HOP_W | Next hop for the row |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | A rule matched |
| res_hop | output | HOP_W | Next hop on a hit, else 0 |
| res_rows | output | CNT_W | Second-level rows enabled for this lookup |

## Verification
The bench loads the first-level table with nested prefixes, including a longer prefix placed ahead of a shorter one. It then checks that a shallow entry never shadows a deeper one. If the priority were reversed, keys under the longer prefix would be sent to the wrong partition and return the shorter rule's hop. A rule placed outside the selected window matches some keys, and it must never be returned. If the window were ignored, that rule would win. Other cases are a window running past the last row, which would report too many rows if not clipped, a zero-length window, and a first-level miss after an entry has been deleted. A stream of keys presented on consecutive cycles catches any stall, reordering or wrong latency.

// File: rtl/pfx_lookup_pkg.sv
package pfx_lookup_pkg;
    // Default geometry of the lookup
    localparam int DEF_KEY_W   = 6;
    localparam int DEF_IX_ROWS = 8;
    localparam int DEF_DT_ROWS = 16;
    localparam int DEF_HOP_W   = 8;

    // Ternary compare: bits with care=0 are wildcards
    function automatic logic tern_hit(input logic [63:0] key,
                                      input logic [63:0] value,
                                      input logic [63:0] care);
        return ((key ^ value) & care) == 64'd0;
    endfunction

    // Row r lies inside [start, start+count), all as plain integers
    function automatic logic in_window(input int row, input int start, input int count);
        return (row >= start) && (row < start + count);
    endfunction
endpackage

// File: rtl/tern_array.sv
module tern_array
    import pfx_lookup_pkg::*;
#(
    parameter int KW   = DEF_KEY_W,
    parameter int ROWS = DEF_DT_ROWS,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_row,
    input  logic            wr_valid,
    input  logic [KW-1:0]   wr_value,
    input  logic [KW-1:0]   wr_care,
    input  logic [KW-1:0]   key,
    input  logic [ROWS-1:0] enable,
    output logic [ROWS-1:0] match
);
    logic [KW-1:0]   val_q  [ROWS];
    logic [KW-1:0]   care_q [ROWS];
    logic [ROWS-1:0] vld_q;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q[r]  <= 1'b0;
                val_q[r]  <= '0;
                care_q[r] <= '0;
            end else if (wr_en && (wr_row == AW'(r))) begin
                vld_q[r]  <= wr_valid;
                val_q[r]  <= wr_value;
                care_q[r] <= wr_care;
            end
        end

        assign match[r] = enable[r] && vld_q[r] &&
                          tern_hit(64'(key), 64'(val_q[r]), 64'(care_q[r]));
    end

    // R8: a write lands in its row at the edge it is sampled
    a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst)) |-> (vld_q[$past(wr_row)] == $past(wr_valid)));
endmodule

// File: rtl/first_hit.sv
module first_hit #(
    parameter int ROWS = 16,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic [ROWS-1:0] req,
    output logic            found,
    output logic [AW-1:0]   idx
);
    // Lowest-numbered set bit wins: scan from the top so the lowest overwrites
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (req[r]) begin
                found = 1'b1;
                idx   = AW'(r);
            end
        end
    end
endmodule

// File: rtl/word_store.sv
module word_store #(
    parameter int W    = 8,
    parameter int ROWS = 16,
    localparam int AW  = $clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_row,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_row,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)                                 mem_q[r] <= '0;
            else if (wr_en && (wr_row == AW'(r)))    mem_q[r] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_row];
endmodule

// File: rtl/pfx_lookup.sv
module pfx_lookup
    import pfx_lookup_pkg::*;
#(
    parameter int KEY_W   = DEF_KEY_W,
    parameter int IX_ROWS = DEF_IX_ROWS,
    parameter int DT_ROWS = DEF_DT_ROWS,
    parameter int HOP_W   = DEF_HOP_W,
    localparam int IX_AW  = $clog2(IX_ROWS),
    localparam int DT_AW  = $clog2(DT_ROWS),
    localparam int CNT_W  = $clog2(DT_ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_valid,
    input  logic [KEY_W-1:0] key,
    input  logic             ix_wr_en,
    input  logic [IX_AW-1:0] ix_wr_row,
    input  logic             ix_wr_valid,
    input  logic [KEY_W-1:0] ix_wr_value,
    input  logic [KEY_W-1:0] ix_wr_care,
    input  logic [DT_AW-1:0] ix_wr_start,
    input  logic [CNT_W-1:0] ix_wr_count,
    input  logic             dt_wr_en,
    input  logic [DT_AW-1:0] dt_wr_row,
    input  logic             dt_wr_valid,
    input  logic [KEY_W-1:0] dt_wr_value,
    input  logic [KEY_W-1:0] dt_wr_care,
    input  logic [HOP_W-1:0] dt_wr_hop,
    output logic             res_valid,
    output logic             res_hit,
    output logic [HOP_W-1:0] res_hop,
    output logic [CNT_W-1:0] res_rows
);
    // Partition descriptor carried from stage 1 to stage 2
    typedef struct packed {
        logic [DT_AW-1:0] start;
        logic [CNT_W-1:0] count;
    } part_t;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [KEY_W-1:0] key;
        part_t            part;
    } stage1_t;

    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [HOP_W-1:0] hop;
        logic [CNT_W-1:0] rows;
    } result_t;

    // ---------------- Stage 1: index search ----------------
    logic [IX_ROWS-1:0] ix_match;
    logic               ix_found;
    logic [IX_AW-1:0]   ix_sel;
    part_t              ix_part;

    tern_array #(.KW(KEY_W), .ROWS(IX_ROWS)) u_ix_tcam (
        .clk(clk), .rst(rst),
        .wr_en(ix_wr_en), .wr_row(ix_wr_row), .wr_valid(ix_wr_valid),
        .wr_value(ix_wr_value), .wr_care(ix_wr_care),
        .key(key), .enable({IX_ROWS{1'b1}}), .match(ix_match)
    );

    first_hit #(.ROWS(IX_ROWS)) u_ix_pick (
        .req(ix_match), .found(ix_found), .idx(ix_sel)
    );

    word_store #(.W($bits(part_t)), .ROWS(IX_ROWS)) u_ix_mem (
        .clk(clk), .rst(rst),
        .wr_en(ix_wr_en), .wr_row(ix_wr_row),
        .wr_data({ix_wr_start, ix_wr_count}),
        .rd_row(ix_sel), .rd_data(ix_part)
    );

    stage1_t s1_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.valid <= key_valid;
            s1_q.hit   <= key_valid && ix_found;
            s1_q.key   <= key;
            s1_q.part  <= ix_part;
        end
    end

    // ---------------- Stage 2: windowed data search ----------------
    logic [DT_ROWS-1:0] dt_enable;
    logic [DT_ROWS-1:0] dt_match;
    logic               dt_found;
    logic [DT_AW-1:0]   dt_sel;
    logic [HOP_W-1:0]   dt_hop;
    logic [CNT_W-1:0]   win_rows;

    for (genvar r = 0; r < DT_ROWS; r++) begin : g_win
        assign dt_enable[r] = s1_q.hit &&
                              in_window(r, int'(s1_q.part.start), int'(s1_q.part.count));
    end

    assign win_rows = CNT_W'($countones(dt_enable));

    tern_array #(.KW(KEY_W), .ROWS(DT_ROWS)) u_dt_tcam (
        .clk(clk), .rst(rst),
        .wr_en(dt_wr_en), .wr_row(dt_wr_row), .wr_valid(dt_wr_valid),
        .wr_value(dt_wr_value), .wr_care(dt_wr_care),
        .key(s1_q.key), .enable(dt_enable), .match(dt_match)
    );

    first_hit #(.ROWS(DT_ROWS)) u_dt_pick (
        .req(dt_match), .found(dt_found), .idx(dt_sel)
    );

    word_store #(.W(HOP_W), .ROWS(DT_ROWS)) u_dt_mem (
        .clk(clk), .rst(rst),
        .wr_en(dt_wr_en), .wr_row(dt_wr_row), .wr_data(dt_wr_hop),
        .rd_row(dt_sel), .rd_data(dt_hop)
    );

    result_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= s1_q.valid;
            res_q.hit   <= s1_q.valid && dt_found;
            res_q.hop   <= (s1_q.valid && dt_found) ? dt_hop : '0;
            res_q.rows  <= s1_q.valid ? win_rows : '0;
        end
    end

    assign res_valid = res_q.valid;
    assign res_hit   = res_q.hit;
    assign res_hop   = res_q.hop;
    assign res_rows  = res_q.rows;

    // ---------------- Assertions ----------------
    // R7: every accepted key advances one stage per edge
    a_r7_stage1_follows: assert property (@(posedge clk) disable iff (rst)
        key_valid |=> s1_q.valid);
    a_r7_result_follows: assert property (@(posedge clk) disable iff (rst)
        s1_q.valid |=> res_valid);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !s1_q.valid |=> !res_valid);

    // R5: first-level miss gives an empty result
    a_r5_index_miss: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && !s1_q.hit) |=> (res_valid && !res_hit && res_hop == '0 && res_rows == '0));

    // R3: enabled rows never exceed the descriptor's count
    a_r3_window_bound: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && s1_q.hit) |=> (res_rows <= $past(s1_q.part.count)));

    // R6/R9: a hit needs at least one enabled row
    a_r9_hit_needs_rows: assert property (@(posedge clk) disable iff (rst)
        res_hit |-> (res_valid && res_rows != '0));
endmodule

// File: tb/pfx_lookup_test.sv
module pfx_lookup_test;
    localparam int KW  = 6;
    localparam int HW  = 8;
    localparam int CW  = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          key_valid = 1'b0;
    logic [KW-1:0] key = '0;
    logic          ix_wr_en = 1'b0;
    logic [2:0]    ix_wr_row = '0;
    logic          ix_wr_valid = 1'b0;
    logic [KW-1:0] ix_wr_value = '0, ix_wr_care = '0;
    logic [3:0]    ix_wr_start = '0;
    logic [CW-1:0] ix_wr_count = '0;
    logic          dt_wr_en = 1'b0;
    logic [3:0]    dt_wr_row = '0;
    logic          dt_wr_valid = 1'b0;
    logic [KW-1:0] dt_wr_value = '0, dt_wr_care = '0;
    logic [HW-1:0] dt_wr_hop = '0;
    logic          res_valid, res_hit;
    logic [HW-1:0] res_hop;
    logic [CW-1:0] res_rows;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    pfx_lookup uut (
        .clk(clk), .rst(rst), .key_valid(key_valid), .key(key),
        .ix_wr_en(ix_wr_en), .ix_wr_row(ix_wr_row), .ix_wr_valid(ix_wr_valid),
        .ix_wr_value(ix_wr_value), .ix_wr_care(ix_wr_care),
        .ix_wr_start(ix_wr_start), .ix_wr_count(ix_wr_count),
        .dt_wr_en(dt_wr_en), .dt_wr_row(dt_wr_row), .dt_wr_valid(dt_wr_valid),
        .dt_wr_value(dt_wr_value), .dt_wr_care(dt_wr_care), .dt_wr_hop(dt_wr_hop),
        .res_valid(res_valid), .res_hit(res_hit), .res_hop(res_hop), .res_rows(res_rows)
    );

    typedef struct packed {
        logic [KW-1:0] key;
        logic          hit;
        logic [HW-1:0] hop;
        logic [CW-1:0] rows;
    } vec_t;

    // key, hit, hop, rows   (tags name the requirement each one targets)
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{6'b000101, 1'b1, 8'd6,  5'd2},  // R2 R4 longest in 00* window
        '{6'b001010, 1'b1, 8'd3,  5'd2},  // R4 shorter row in same window
        '{6'b011000, 1'b1, 8'd7,  5'd3},  // R2 0* partition, 011*
        '{6'b010111, 1'b1, 8'd4,  5'd3},  // R4 01*
        '{6'b010000, 1'b1, 8'd4,  5'd3},  // R4 01* again
        '{6'b110000, 1'b1, 8'd5,  5'd2},  // R2 * partition, 11*
        '{6'b100000, 1'b1, 8'd1,  5'd2},  // R4 row 8 (10*) outside window ignored
        '{6'b111110, 1'b1, 8'd9,  5'd2},  // R3 clipped window hit
        '{6'b111100, 1'b0, 8'd0,  5'd2},  // R6 R3 clipped window miss
        '{6'b111000, 1'b0, 8'd0,  5'd0},  // R9 zero-length window
        '{6'b001111, 1'b1, 8'd3,  5'd2}   // R7 stream tail
    };

    function automatic logic [KW-1:0] care_of(input int len);
        return ~((KW'(1) << (KW - len)) - KW'(1));
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ix_write(input int row, input bit v, input logic [KW-1:0] val,
                            input int len, input int start, input int cnt);
        @(negedge clk);
        ix_wr_en = 1'b1; ix_wr_row = 3'(row); ix_wr_valid = v;
        ix_wr_value = val; ix_wr_care = care_of(len);
        ix_wr_start = 4'(start); ix_wr_count = CW'(cnt);
        @(negedge clk);
        ix_wr_en = 1'b0;
    endtask

    task automatic dt_write(input int row, input bit v, input logic [KW-1:0] val,
                            input int len, input int hop);
        @(negedge clk);
        dt_wr_en = 1'b1; dt_wr_row = 4'(row); dt_wr_valid = v;
        dt_wr_value = val; dt_wr_care = care_of(len); dt_wr_hop = HW'(hop);
        @(negedge clk);
        dt_wr_en = 1'b0;
    endtask

    // Single lookup: result is sampled two edges after the key is taken
    task automatic lookup(input logic [KW-1:0] k, input string req,
                          input bit ehit, input int ehop, input int erows);
        @(negedge clk);
        key = k; key_valid = 1'b1;
        @(negedge clk);
        key_valid = 1'b0;
        @(negedge clk);
        check(res_valid && res_hit == ehit && res_hop == HW'(ehop) && res_rows == CW'(erows),
              req, {res_valid, res_hit, 8'(res_hop), 8'(res_rows)},
              {1'b1, ehit, 8'(ehop), 8'(erows)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(res_valid == 1'b0, "R1 reset", 32'(res_valid), 32'd0);
        lookup(6'b101010, "R1 empty tables", 1'b0, 0, 0);

        // First level: longer prefixes first
        ix_write(0, 1, 6'b111100, 4, 14, 4);  // 1111* -> rows 14.. (clipped)
        ix_write(1, 1, 6'b111000, 4,  9, 0);  // 1110* -> empty window
        ix_write(2, 1, 6'b000000, 2,  0, 2);  // 00*
        ix_write(3, 1, 6'b000000, 1,  2, 3);  // 0*
        ix_write(4, 1, 6'b000000, 0,  5, 2);  // *
        // Second level partitions
        dt_write(0,  1, 6'b000000, 3, 6);   // 000*
        dt_write(1,  1, 6'b000000, 2, 3);   // 00*
        dt_write(2,  1, 6'b011000, 3, 7);   // 011*
        dt_write(3,  1, 6'b010000, 2, 4);   // 01*
        dt_write(4,  1, 6'b000000, 1, 2);   // 0*
        dt_write(5,  1, 6'b110000, 2, 5);   // 11*
        dt_write(6,  1, 6'b000000, 0, 1);   // *
        dt_write(8,  1, 6'b100000, 2, 8);   // 10* outside every window
        dt_write(14, 1, 6'b111110, 5, 9);   // 11111*

        // Streamed vectors, one key per cycle (R7)
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check(res_valid && res_hit == VECS[i-2].hit && res_hop == VECS[i-2].hop &&
                      res_rows == VECS[i-2].rows,
                      $sformatf("R7/R2-R9 vector %0d", i - 2),
                      {res_valid, res_hit, 8'(res_hop), 8'(res_rows)},
                      {1'b1, VECS[i-2].hit, 8'(VECS[i-2].hop), 8'(VECS[i-2].rows)});
            end
            if (i < NV) begin
                key = VECS[i].key; key_valid = 1'b1;
            end else begin
                key_valid = 1'b0;
            end
        end
        @(negedge clk);
        @(negedge clk);
        // R7: no key, no result
        check(res_valid == 1'b0, "R7 idle", 32'(res_valid), 32'd0);

        // R8: delete data row 0, 000* falls back to 00*
        dt_write(0, 0, 6'b000000, 3, 6);
        lookup(6'b000101, "R8 data delete", 1'b1, 3, 2);
        // R5 + R8: delete catch-all index entry -> first-level miss
        ix_write(4, 0, 6'b000000, 0, 5, 2);
        lookup(6'b101010, "R5 index miss", 1'b0, 0, 0);
        // R8: rewrite it pointing at row 8 window of one
        ix_write(4, 1, 6'b000000, 0, 8, 1);
        lookup(6'b101010, "R8 index rewrite", 1'b1, 8, 1);
        // R6: window holds no match for this key
        lookup(6'b110000, "R6 window miss", 1'b0, 0, 1);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) check(1'b0, "watchdog", 32'(cyc), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule